// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block is a unified translation buffer, shared by instruction and data accesses, that turns a virtual address into a physical or shadow address within the same cycle. It has a parameterised number of entries. Each entry carries its own size code, so a single 4 KiB page and an aligned superpage of up to 2048 base pages can sit side by side in the same array. The 12-bit page offset is passed through unchanged. On a miss the block only flags the miss. Software handles the miss and then installs the mapping through an explicit write port.

The write port either fills an entry or invalidates entries. A fill first takes the lowest-numbered empty slot. When no slot is empty, it takes the least-recently-used entry, where recency is kept across the whole array and is refreshed by hits and fills. A fill whose page numbers are not aligned to its size is refused and flagged. A write in a cycle takes precedence over a lookup in the same cycle.

Top module: `xlat_buf`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss and `wr_err` is low.
- R2: A lookup with `lk_valid` high and `wr_en` low raises exactly one of `lk_hit` or `lk_miss` combinationally in the same cycle.
- R3: On a hit, `lk_pa[11:0]` equals `lk_va[11:0]`. Above bit 11, the low `size` bits of the page number come from the virtual address and the remaining bits come from the stored frame.
- R4: The size code `wr_size` is log2 of the number of base pages, from 0 to 11. An entry of size s matches any virtual page number that agrees with its tag above bit s-1. A code above 11 is refused.
- R5: A fill (`wr_op`=0) whose virtual or physical page number has any of its low `wr_size` bits set, or whose size code is above 11, raises `wr_err` for the cycle after the write and changes no entry.
- R6: An accepted fill goes to the lowest-indexed invalid entry when any entry is invalid.
- R7: When all entries are valid, an accepted fill replaces the least-recently-used entry. Recency is updated only by hits and accepted fills, not by misses, refused fills or invalidates.
- R8: When several valid entries match a lookup, the lowest-indexed one supplies the translation.
- R9: An invalidate (`wr_op`=1) clears every valid entry whose range covers `wr_vpn` and leaves the other entries intact.
- R10: While `wr_en` is high, a lookup raises neither `lk_hit` nor `lk_miss` and does not update recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W (32) | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_miss | output | 1 | Lookup miss, same cycle |
| lk_pa | output | PA_W (32) | Translated physical or shadow address, valid with lk_hit |
| wr_en | input | 1 | Write request (fill or invalidate) |
| wr_op | input | 1 | 0 = fill, 1 = invalidate |
| wr_vpn | input | VA_W-12 | Virtual page number of the write |
| wr_ppn | input | PA_W-12 | Frame number for a fill |
| wr_size | input | 4 | log2 of base pages per entry for a fill |
| wr_err | output | 1 | Fill refused, one cycle after the write |

## Verification
A corrupted size code or tag shows up at the very next lookup that touches that range. It appears either as a spurious miss or as a hit whose address bits are taken from the wrong source at the wrong position. A fault in the recency state stays hidden until the array is full. It shows only on the lookup after the next replacing fill: a mapping that should have survived now misses, or one that should be gone still hits. The bench therefore fills a small array completely, builds a known use order, and probes every surviving and evicted mapping right after each replacement.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int OFF_W    = 12;
  localparam int SZ_W     = 4;
  localparam int MAX_LOG2 = 11;
  localparam logic OP_FILL  = 1'b0;
  localparam logic OP_INVAL = 1'b1;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int VPN_W = 20,
  parameter int SZ_W  = 4
) (
  input  logic             ent_valid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [SZ_W-1:0]  ent_size,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             match
);
  logic [VPN_W-1:0] keep;
  always_comb begin
    keep  = {VPN_W{1'b1}} << ent_size;
    match = ent_valid && (((ent_vpn ^ probe_vpn) & keep) == '0);
  end
endmodule

// File: rtl/xlat_first_one.sv
module xlat_first_one #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [IW-1:0] age_q [N];
  logic [IW-1:0] age_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (IW'(i) == touch_idx)
        age_d[i] = '0;
      else if (age_q[i] < age_q[touch_idx])
        age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == IW'(N - 1)) victim_idx = IW'(i);
  end

  // R7
  touched_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> victim_idx != $past(touch_idx));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic [PA_W-1:0]       lk_pa,
  input  logic                  wr_en,
  input  logic                  wr_op,
  input  logic [VA_W-OFF_W-1:0] wr_vpn,
  input  logic [PA_W-OFF_W-1:0] wr_ppn,
  input  logic [SZ_W-1:0]       wr_size,
  output logic                  wr_err
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [SZ_W-1:0]    size_q [ENTRIES];
  logic               err_q, err_d;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_match, inv_match;
  logic [IW-1:0]      hit_idx, free_idx, lru_idx, fill_idx, touch_idx;
  logic               any_hit, any_free, touch_en;
  logic               fill_req, fill_ok, fill_go, inval_go;
  logic [VPN_W-1:0]   vpn_low;
  logic [PPN_W-1:0]   ppn_low, keep_p, frame;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_match #(.VPN_W(VPN_W), .SZ_W(SZ_W)) u_lk (
      .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_size(size_q[g]),
      .probe_vpn(lk_vpn), .match(lk_match[g]));
    xlat_match #(.VPN_W(VPN_W), .SZ_W(SZ_W)) u_inv (
      .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_size(size_q[g]),
      .probe_vpn(wr_vpn), .match(inv_match[g]));
  end

  xlat_first_one #(.N(ENTRIES), .IW(IW)) u_hit_sel (
    .vec(lk_match), .idx(hit_idx), .any(any_hit));
  xlat_first_one #(.N(ENTRIES), .IW(IW)) u_free_sel (
    .vec(~valid_q), .idx(free_idx), .any(any_free));
  xlat_lru #(.N(ENTRIES), .IW(IW)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
    .touch_idx(touch_idx), .victim_idx(lru_idx));

  // Lookup path
  always_comb begin
    lk_hit  = lk_valid && !wr_en && any_hit;
    lk_miss = lk_valid && !wr_en && !any_hit;
    keep_p  = {PPN_W{1'b1}} << size_q[hit_idx];
    frame   = (ppn_q[hit_idx] & keep_p) | (PPN_W'(lk_vpn) & ~keep_p);
    lk_pa   = {frame, lk_va[OFF_W-1:0]};
  end

  // Write path decode
  always_comb begin
    vpn_low  = ~({VPN_W{1'b1}} << wr_size);
    ppn_low  = ~({PPN_W{1'b1}} << wr_size);
    fill_req = wr_en && (wr_op == OP_FILL);
    fill_ok  = (wr_size <= SZ_W'(MAX_LOG2)) &&
               ((wr_vpn & vpn_low) == '0) && ((wr_ppn & ppn_low) == '0);
    fill_go  = fill_req && fill_ok;
    inval_go = wr_en && (wr_op == OP_INVAL);
    err_d    = fill_req && !fill_ok;
    fill_idx = any_free ? free_idx : lru_idx;
    touch_en = fill_go || lk_hit;
    touch_idx = fill_go ? fill_idx : hit_idx;
    valid_d  = valid_q;
    if (inval_go) valid_d = valid_q & ~inv_match;
    if (fill_go)  valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (fill_go || inval_go) valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_idx]  <= wr_vpn;
      ppn_q[fill_idx]  <= wr_ppn;
      size_q[fill_idx] <= wr_size;
    end
  end

  assign wr_err = err_q;

  // R10
  write_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !lk_hit && !lk_miss);
  // R5
  refused_fill_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> valid_q == $past(valid_q));
  // R6
  free_fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && any_free |=> $countones(valid_q) == $countones($past(valid_q)) + 1);
  // R9
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_go |=> (valid_q & $past(inv_match)) == '0);
  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
endmodule

// File: tb/sim_xlat_buf.sv
`timescale 1ns/100ps
module sim_xlat_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss, wr_err;
  logic [31:0] lk_pa;
  logic        wr_en = 1'b0, wr_op = 1'b0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [3:0]  wr_size = '0;

  int checks = 0, bad = 0;

  typedef struct {
    bit          hit;
    bit          miss;
    logic [31:0] pa;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  xlat_buf #(.ENTRIES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
    .wr_en(wr_en), .wr_op(wr_op), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .wr_size(wr_size), .wr_err(wr_err));

  // monitor: pops an expected item for every lookup cycle
  always @(negedge clk) begin
    #1;
    if (lk_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty: actual hit=%0b miss=%0b expected an item", lk_hit, lk_miss);
      end else begin
        e = sb.pop_front();
        if (lk_hit !== e.hit || lk_miss !== e.miss || (e.hit && lk_pa !== e.pa)) begin
          bad++;
          $display("FAIL %s va=%h: actual hit=%0b miss=%0b pa=%h expected hit=%0b miss=%0b pa=%h",
                   e.tag, lk_va, lk_hit, lk_miss, lk_pa, e.hit, e.miss, e.pa);
        end
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input bit h, input logic [31:0] pa, input string tag);
    exp_t e;
    @(negedge clk);
    e.hit = h; e.miss = !h; e.pa = pa; e.tag = tag;
    sb.push_back(e);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic write(input logic op, input logic [19:0] v, input logic [19:0] p,
                       input logic [3:0] s, input bit exp_err, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_vpn = v; wr_ppn = p; wr_size = s;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    checks++;
    if (wr_err !== exp_err) begin
      bad++;
      $display("FAIL %s err: actual %0b expected %0b", tag, wr_err, exp_err);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    checks++;
    if (wr_err !== 1'b0) begin bad++; $display("FAIL R1 err: actual %0b expected 0", wr_err); end
    lookup(32'h0000_4080, 0, 0, "R1 empty miss");
    // base page, idx0
    write(1'b0, 20'h00004, 20'h40138, 4'd0, 0, "R6 fill base");
    lookup(32'h0000_4080, 1, 32'h4013_8080, "R3 base translate");
    // 4-page superpage, idx1
    write(1'b0, 20'h00010, 20'h80240, 4'd2, 0, "R4 fill size2");
    lookup(32'h0001_3abc, 1, 32'h8024_3abc, "R4 superpage high page");
    lookup(32'h0001_4000, 0, 0, "R4 outside superpage");
    // refused fills
    write(1'b0, 20'h00021, 20'h00000, 4'd1, 1, "R5 vpn misaligned");
    write(1'b0, 20'h00020, 20'h00001, 4'd1, 1, "R5 ppn misaligned");
    write(1'b0, 20'h00000, 20'h00000, 4'd12, 1, "R4 size above 11");
    lookup(32'h0002_1000, 0, 0, "R5 refused fill absent");
    // largest size, idx2
    write(1'b0, 20'h00800, 20'h01000, 4'd11, 0, "R4 fill size11");
    lookup(32'h00FF_F123, 1, 32'h017F_F123, "R3 size11 translate");
    // overlapping base page, idx3
    write(1'b0, 20'h00010, 20'h55555, 4'd0, 0, "R6 fill overlap");
    lookup(32'h0001_0000, 1, 32'h8024_0000, "R8 lowest index wins");
    // use order now 1,3,2,0; touch idx0 -> LRU is idx2
    lookup(32'h0000_4000, 1, 32'h4013_8000, "R7 touch idx0");
    write(1'b0, 20'h00100, 20'h00abc, 4'd0, 0, "R7 fill full array");
    lookup(32'h00FF_F123, 0, 0, "R7 LRU entry evicted");
    lookup(32'h0000_4000, 1, 32'h4013_8000, "R7 survivor idx0");
    lookup(32'h0001_3000, 1, 32'h8024_3000, "R7 survivor idx1");
    lookup(32'h0010_0000, 1, 32'h00ab_c000, "R7 new entry");
    // invalidate covering range of idx1 only
    write(1'b1, 20'h00011, 20'h00000, 4'd0, 0, "R9 invalidate");
    lookup(32'h0001_2000, 0, 0, "R9 superpage gone");
    lookup(32'h0001_0000, 1, 32'h5555_5000, "R9 base survivor");
    // free slot idx1 reused before LRU
    write(1'b0, 20'h00200, 20'h00777, 4'd0, 0, "R6 refill free slot");
    lookup(32'h0020_0010, 1, 32'h0077_7010, "R6 refilled");
    lookup(32'h0000_4000, 1, 32'h4013_8000, "R6 idx0 kept");
    lookup(32'h0010_0000, 1, 32'h00ab_c000, "R6 idx2 kept");
    lookup(32'h0001_0000, 1, 32'h5555_5000, "R6 idx3 kept");
    // R10: write and lookup together
    begin
      exp_t e;
      @(negedge clk);
      e.hit = 0; e.miss = 0; e.pa = 0; e.tag = "R10 write has priority";
      sb.push_back(e);
      lk_valid = 1'b1; lk_va = 32'h0000_4000;
      wr_en = 1'b1; wr_op = 1'b1; wr_vpn = 20'hFFFFF;
      @(negedge clk);
      lk_valid = 1'b0; wr_en = 1'b0;
    end
    lookup(32'h0000_4000, 1, 32'h4013_8000, "R2 lookup after write");
    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2 pending: actual %0d expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule